// File: doc/BRIEF.md
# Keyed-Command Watchdog Timer

This block is a runaway detector for a processor subsystem. A binary up-counter advances once per system clock. When it completes the detection period chosen by software, the block emits a single-cycle non-maskable interrupt request. It then wraps to zero and keeps counting. Software that is still healthy keeps the request from ever firing by writing a restart key to a command register before each period runs out.

Software reaches the block through a write-only port. The port has a strobe, a one-bit register select and a byte of data. Register 0 holds the mode settings and is always visible on a readback output. Register 1 takes command keys. The timer runs from the moment reset is released. It can be stopped only when two writes arrive in order: first the enable bit in the mode register goes to zero, then the disable key is written. Three power-state inputs act on the count. The debug input freezes it. The stop input clears it and holds it at zero. The idle input pauses it unless the mode register allows counting in idle.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the mode readback is 0x01: bit 0 (enable) = 1, bits 2:1 (period code) = 0, bit 3 (idle-run) = 0, bits 7:4 = 0. Counting begins without any register write, and the first request follows 2^PER_BASE counting cycles.
- R2: `nmi_pulse` is high for exactly one cycle. That cycle is the one after the counting cycle that completes the period. The counter then restarts from zero, so requests repeat once per period.
- R3: Period code k (mode bits 2:1) sets the period to 2^(PER_BASE + k*PER_STEP) counting cycles.
- R4: A write of 0x4E to register 1 returns the count to zero in that cycle, and no request comes from that cycle.
- R5: A write of 0xB1 to register 1 while mode bit 0 is 1 has no effect on the timer.
- R6: A write of 0xB1 to register 1 while mode bit 0 is 0 stops the timer and clears the count. No requests follow. A later mode write with bit 0 = 1 restarts counting from zero.
- R7: Any command byte other than 0x4E and 0xB1 is ignored.
- R8: While `dbg_halt` is high the count holds its value.
- R9: While `idle_mode` is high the count advances only if mode bit 3 is 1. Otherwise it holds.
- R10: While `stop_mode` is high the count is forced to zero and no requests are issued. This input takes priority over every other input.
- R11: A mode write stores data bits 3:0. Readback shows bits 7:4 as zero. A mode write with bit 0 = 1 while the timer is running does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = mode register, 1 = command register |
| wr_data | input | 8 | Write data |
| dbg_halt | input | 1 | Debug state: freeze the count |
| idle_mode | input | 1 | Idle state: count only if idle-run is set |
| stop_mode | input | 1 | Stop state: clear and hold the count |
| mode_q | output | 8 | Mode register readback |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The counter is internal, so a wrong count shows at the ports only through when `nmi_pulse` fires. A count that is off by one, a bad wrap or a wrong period mask moves the next request by one or more cycles, and that shows within one period. A gating fault shows as a request that comes early or late after a debug, idle or stop window. A fault in key decoding shows as a missing or extra request one period after the write. The bench therefore runs a cycle-exact arithmetic model of the period, compares the request line and the readback on every cycle, and keeps each scenario running past at least one period boundary.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_RESTART = 8'h4E;
  localparam logic [7:0] KEY_DISABLE = 8'hB1;

  typedef struct packed {
    logic       idle_run;
    logic [1:0] psel;
    logic       en;
  } mode_t;

  localparam mode_t MODE_RESET = '{idle_run: 1'b0, psel: 2'd0, en: 1'b1};
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output mode_t      mode_o,
  output logic       run_o,
  output logic       clear_o
);
  mode_t mode_q, mode_d;
  logic  run_q, run_d;
  logic  mode_wr, cmd_wr, key_restart, key_disable, rearm;

  always_comb begin
    mode_wr     = wr_en & ~wr_addr;
    cmd_wr      = wr_en & wr_addr;
    key_restart = cmd_wr & (wr_data == KEY_RESTART);
    key_disable = cmd_wr & (wr_data == KEY_DISABLE) & ~mode_q.en;
    rearm       = mode_wr & wr_data[0] & ~run_q;

    mode_d = mode_q;
    if (mode_wr) mode_d = mode_t'(wr_data[3:0]);

    run_d = run_q;
    if (rearm)            run_d = 1'b1;
    else if (key_disable) run_d = 1'b0;

    clear_o = key_restart | key_disable | rearm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      run_q  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
    end
  end

  assign mode_o = mode_q;
  assign run_o  = run_q;

  // R5: the disable key has no effect while the enable bit is still set
  a_r5_disable_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data == KEY_DISABLE && mode_q.en) |=> (run_q == $past(run_q)));

  // R6: a mode write with enable set brings a stopped timer back
  a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && wr_data[0]) |=> run_q);

  // R7: a command byte that is not a key leaves run state alone
  a_r7_other_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data != KEY_DISABLE) |=> (run_q == $past(run_q)));
endmodule

// File: rtl/wdt_gate.sv
module wdt_gate (
  input  logic run_i,
  input  logic idle_run_i,
  input  logic dbg_i,
  input  logic idle_i,
  input  logic stop_i,
  input  logic clear_req_i,
  output logic cnt_en_o,
  output logic cnt_clr_o
);
  logic idle_block;

  always_comb begin
    idle_block = idle_i & ~idle_run_i;
    cnt_clr_o  = stop_i | clear_req_i | ~run_i;
    cnt_en_o   = run_i & ~stop_i & ~dbg_i & ~idle_block;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int PER_BASE = 15,
  parameter int PER_STEP = 2,
  localparam int CNT_W   = PER_BASE + 3 * PER_STEP
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en_i,
  input  logic       cnt_clr_i,
  input  logic [1:0] psel_i,
  output logic       ovf_o
);
  logic [CNT_W-1:0] mask_tab [4];
  logic [CNT_W-1:0] mask, cnt_q, cnt_d;
  logic             at_end, ovf_d, ovf_q;

  for (genvar i = 0; i < 4; i++) begin : g_mask
    localparam int EXP = PER_BASE + i * PER_STEP;
    assign mask_tab[i] = {CNT_W{1'b1}} >> (CNT_W - EXP);
  end

  always_comb begin
    mask   = mask_tab[psel_i];
    at_end = (cnt_q & mask) == mask;
    cnt_d  = cnt_q;
    ovf_d  = 1'b0;
    if (cnt_clr_i) begin
      cnt_d = '0;
    end else if (cnt_en_i) begin
      cnt_d = (cnt_q + 1'b1) & mask;
      ovf_d = at_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign ovf_o = ovf_q;

  // R2: a request never lasts two cycles
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q);

  // R4, R10: any clear request leaves the count at zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> (cnt_q == '0));

  // R8: with counting gated off and no clear, the count is frozen
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_i && !cnt_clr_i) |=> $stable(cnt_q));

  // R10: a clear cycle never produces a request
  a_r10_no_req_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> !ovf_q);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int PER_BASE = 15,
  parameter int PER_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       dbg_halt,
  input  logic       idle_mode,
  input  logic       stop_mode,
  output logic [7:0] mode_q,
  output logic       nmi_pulse
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  mode_t      mode;
  logic       run, clear_req, cnt_en, cnt_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdt_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode_o  (mode),
    .run_o   (run),
    .clear_o (clear_req)
  );

  wdt_gate u_gate (
    .run_i       (run),
    .idle_run_i  (mode.idle_run),
    .dbg_i       (dbg_halt),
    .idle_i      (idle_mode),
    .stop_i      (stop_mode),
    .clear_req_i (clear_req),
    .cnt_en_o    (cnt_en),
    .cnt_clr_o   (cnt_clr)
  );

  wdt_counter #(
    .PER_BASE (PER_BASE),
    .PER_STEP (PER_STEP)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cnt_en_i  (cnt_en),
    .cnt_clr_i (cnt_clr),
    .psel_i    (mode.psel),
    .ovf_o     (nmi_pulse)
  );

  assign mode_q = {4'b0000, mode};

  // R6: a stopped timer raises no request
  a_r6_stopped_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    !run |-> !nmi_pulse);

  // R10: a request is never raised in the cycle after stop was high
  a_r10_stop_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    stop_mode |=> !nmi_pulse);

  // R11: the upper readback bits stay zero
  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode_q[7:4] == 4'b0000);
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 3;
  localparam int STEP = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_addr;
  logic [7:0] wr_data;
  logic       dbg_halt, idle_mode, stop_mode;
  logic [7:0] mode_q;
  logic       nmi_pulse;

  int vectors = 0;
  int miscompares = 0;

  logic [3:0] m_mode;
  bit         m_run;
  int         m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog #(.PER_BASE(BASE), .PER_STEP(STEP)) i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dbg_halt(dbg_halt), .idle_mode(idle_mode),
    .stop_mode(stop_mode), .mode_q(mode_q), .nmi_pulse(nmi_pulse)
  );

  task automatic check(input string tag, input logic [7:0] act_mode, input logic act_nmi,
                       input logic [7:0] exp_mode, input logic exp_nmi);
    vectors++;
    if (act_mode !== exp_mode || act_nmi !== exp_nmi) begin
      miscompares++;
      $display("FAIL %s t=%0t mode_q=%02h nmi=%b expected mode_q=%02h nmi=%b",
               tag, $time, act_mode, act_nmi, exp_mode, exp_nmi);
    end
  endtask

  // One clock: model the edge from current inputs, then compare after it.
  task automatic step(input string tag);
    logic [3:0] old_mode = m_mode;
    bit  old_run = m_run;
    bit  clr = 0;
    bit  en;
    bit  exp_nmi = 0;
    int  per = 1 << (BASE + old_mode[2:1] * STEP);
    if (wr_en && !wr_addr) begin
      if (wr_data[0] && !old_run) begin m_run = 1; clr = 1; end
      m_mode = wr_data[3:0];
    end
    if (wr_en && wr_addr) begin
      if (wr_data == 8'h4E) clr = 1;
      else if (wr_data == 8'hB1 && !old_mode[0]) begin m_run = 0; clr = 1; end
    end
    en = old_run && !stop_mode && !dbg_halt && (!idle_mode || old_mode[3]);
    if (stop_mode || clr || !old_run) m_cnt = 0;
    else if (en) begin
      exp_nmi = ((m_cnt % per) == per - 1);
      m_cnt = (m_cnt + 1) % per;
    end
    @(posedge clk); #1;
    check(tag, mode_q, nmi_pulse, {4'b0, m_mode}, exp_nmi);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic write(input logic a, input logic [7:0] d, input string tag);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(tag);
    wr_en = 0; wr_addr = 0; wr_data = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired mode_q=%02h nmi=%b expected completion", mode_q, nmi_pulse);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    dbg_halt = 0; idle_mode = 0; stop_mode = 0;
    m_mode = 4'h1; m_run = 1; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", mode_q, nmi_pulse, 8'h01, 1'b0);
    rst_n = 1;
    // two edges for the internal reset synchroniser, no counting yet
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      check("R1 sync", mode_q, nmi_pulse, 8'h01, 1'b0);
    end
    run(20, "R1 first period");
    run(40, "R2 repeat");

    // R3 and R11: sweep period codes while running
    for (int k = 0; k < 4; k++) begin
      write(0, 8'(k << 1) | 8'h01, "R11 mode write");
      run(2 * (1 << (BASE + k * STEP)) + 3, "R3 period");
    end
    write(0, 8'h03, "R3 psel1");
    // R4: restart key before each period ends
    for (int i = 0; i < 10; i++) begin
      run(25, "R4 before key");
      write(1, 8'h4E, "R4 restart");
    end
    run(40, "R4 after");

    write(0, 8'h01, "R3 psel0");
    // R7: every non-key byte
    for (int b = 0; b < 256; b++) begin
      if (b != 8'h4E && b != 8'hB1) begin
        write(1, 8'(b), "R7 ignored byte");
        step("R7 ignored byte");
      end
    end

    // R5: disable key with enable still set
    write(1, 8'hB1, "R5 ignored disable");
    run(20, "R5 still running");
    // R6: two-step disable, then re-enable
    write(0, 8'h00, "R6 clear enable");
    run(20, "R6 still running");
    write(1, 8'hB1, "R6 disable");
    run(100, "R6 stopped");
    write(1, 8'h4E, "R6 restart while stopped");
    run(20, "R6 stopped");
    write(0, 8'h01, "R6 re-enable");
    run(20, "R6 from zero");

    // R8: debug freeze, steady and toggling
    run(3, "R8 pre");
    dbg_halt = 1; run(50, "R8 hold");
    dbg_halt = 0; run(5, "R8 resume");
    for (int i = 0; i < 40; i++) begin
      dbg_halt = i[0]; step("R8 toggle");
    end
    dbg_halt = 0;

    // R9: idle gating
    idle_mode = 1; run(30, "R9 idle paused");
    write(0, 8'h09, "R9 idle-run on");
    run(30, "R9 idle counting");
    write(0, 8'h01, "R9 idle-run off");
    run(10, "R9 idle paused");
    idle_mode = 0; run(20, "R9 resume");

    // R10: stop clears and wins over debug and keys
    run(5, "R10 pre");
    stop_mode = 1; run(10, "R10 stop");
    dbg_halt = 1; run(3, "R10 stop+dbg");
    dbg_halt = 0;
    write(0, 8'h01, "R10 stop+write");
    stop_mode = 0; run(20, "R10 release");

    // R11: mode register storage sweep
    for (int b = 0; b < 256; b += 7) begin
      write(0, 8'(b), "R11 store");
      run(2, "R11 store");
    end
    write(0, 8'h01, "R11 final");
    run(20, "R11 final");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule